// File: doc/BRIEF.md
# PCI Power-Management Capability Controller

This block holds the power-management capability structure of a bus bridge's configuration space and turns the current power state into gating signals for the rest of the bridge. The structure occupies two configuration dwords at a base address set by a parameter. The first dword packs the capability identifier (0x01), the pointer to the next capability, and the fixed capabilities word 0x0202. The second dword carries the control/status word with the power-state field, the bridge-support-extension byte (0x00) and the data byte (0x00).

The power state is a small state machine with three named states: `PS_D0` (fully on), `PS_D1` and `PS_D3HOT`. A configuration write moves it. The named transitions are D0_TO_D1, D0_TO_D3HOT, D1_TO_D0, D1_TO_D3HOT, D3HOT_TO_D0, D3HOT_TO_D1, and a HOLD self-loop. HOLD is taken on every other cycle, including a write that asks for the unsupported D2 code. Outside `PS_D0` the gating outputs stop master activity and stop the claiming of memory and I/O cycles, whatever the command-register enables say. Configuration cycles to the structure are still claimed in every state. An access that the bridge no longer claims therefore ends in a master abort at the requester.

Top module: `pm_cap_ctrl`

## Requirements
- R1: After reset the power state is `PS_D0` (code 00 on `pwr_state`).
- R2: A read of capability dword 0 returns bits [7:0] = 0x01, bits [15:8] = the next-pointer parameter (default 0x00, meaning end of list) and bits [31:16] = 0x0202. The data is on `cfg_rdata`, with `cfg_rvalid` high, in the cycle after the read request.
- R3: A read of capability dword 1 returns the power state in bits [1:0] and zero in bits [15:2]. It also returns 0x00 in the bridge-support-extension byte [23:16] and 0x00 in the data byte [31:24].
- R4: A write to dword 1 with byte enable 0 set loads the power state from write data bits [1:0] (00 = D0, 01 = D1, 11 = D3hot). The new state shows on `pwr_state` after the clock edge that takes the write.
- R5: A write that carries code 10 (D2) is ignored, and the power state keeps its previous value.
- R6: A write to dword 1 with byte enable 0 clear, or any write to dword 0, leaves the power state unchanged and leaves dword 0 reading its fixed value.
- R7: In D1 or D3hot, `mst_allow`, `mem_claim_ok` and `io_claim_ok` are all 0, even with every command enable set.
- R8: In D0, each of the three gating outputs equals its command-register enable input.
- R9: `cfg_hit` is high in the same cycle as a read or write request to either capability dword, in every power state. It is low for any other address, and a read of another address never raises `cfg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd | input | 1 | Configuration read request, one cycle |
| cfg_wr | input | 1 | Configuration write request, one cycle |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_hit | output | 1 | Request addresses the capability structure (claimed) |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a hitting read |
| cfg_rdata | output | 32 | Read data |
| cmd_mst_en | input | 1 | Command-register bus-master enable |
| cmd_mem_en | input | 1 | Command-register memory-space enable |
| cmd_io_en | input | 1 | Command-register I/O-space enable |
| mst_allow | output | 1 | Bridge may start master transactions |
| mem_claim_ok | output | 1 | Bridge may claim memory cycles |
| io_claim_ok | output | 1 | Bridge may claim I/O cycles |
| pwr_state | output | 2 | Current power state code |

## Verification
`cfg_hit` is combinational and is due in the request cycle itself. The bench samples it one nanosecond after driving the request, before the next rising edge. Read data and `cfg_rvalid` are due one edge later, and the power state and the three gating outputs change at the edge that takes a write. For that reason the bench drives every request on a falling edge and checks these results on the following falling edge, when the output has settled half a period after the edge that registered it.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D3HOT = 2'b11
    } pwr_state_e;

    localparam logic [1:0]  CODE_D2      = 2'b10;
    localparam logic [7:0]  PM_CAP_ID    = 8'h01;
    localparam logic [15:0] PM_CAPS_WORD = 16'h0202;
    localparam logic [7:0]  PM_BSE_BYTE  = 8'h00;
    localparam logic [7:0]  PM_DATA_BYTE = 8'h00;

endpackage

// File: rtl/pm_cfg_decode.sv
module pm_cfg_decode #(
    parameter int unsigned ADDR_W = 6,
    parameter logic [ADDR_W-1:0] CAP_DW = 6'h10
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              be0,
    output logic              sel_id,
    output logic              sel_csr,
    output logic              hit,
    output logic              rd_hit,
    output logic              csr_load
);
    localparam logic [ADDR_W-1:0] CSR_DW = CAP_DW + ADDR_W'(1);

    always_comb begin
        sel_id   = (addr == CAP_DW);
        sel_csr  = (addr == CSR_DW);
        hit      = (rd || wr) && (sel_id || sel_csr);
        rd_hit   = rd && (sel_id || sel_csr);
        csr_load = wr && sel_csr && be0;
    end
endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    output pwr_state_e state
);
    pwr_state_e nxt;
    logic       legal;

    assign legal = load && (code != CODE_D2);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_D0;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_D0: begin
                if (legal && code == PS_D1)         nxt = PS_D1;    // D0_TO_D1
                else if (legal && code == PS_D3HOT) nxt = PS_D3HOT; // D0_TO_D3HOT
            end
            PS_D1: begin
                if (legal && code == PS_D0)         nxt = PS_D0;    // D1_TO_D0
                else if (legal && code == PS_D3HOT) nxt = PS_D3HOT; // D1_TO_D3HOT
            end
            PS_D3HOT: begin
                if (legal && code == PS_D0)         nxt = PS_D0;    // D3HOT_TO_D0
                else if (legal && code == PS_D1)    nxt = PS_D1;    // D3HOT_TO_D1
            end
            default: nxt = PS_D0;
        endcase
    end

    assert_reset_d0_R1: assert property (@(posedge clk)
        !rst_n |=> state == PS_D0);

    assert_d2_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code == CODE_D2) |=> $stable(state));

    assert_load_d1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code == 2'b01) |=> state == PS_D1);

    assert_no_load_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(state));
endmodule

// File: rtl/pm_gate.sv
module pm_gate
    import pm_pkg::*;
(
    input  pwr_state_e state,
    input  logic       mst_en,
    input  logic       mem_en,
    input  logic       io_en,
    output logic       mst_ok,
    output logic       mem_ok,
    output logic       io_ok
);
    logic full_on;

    always_comb begin
        full_on = (state == PS_D0);
        mst_ok  = full_on && mst_en;
        mem_ok  = full_on && mem_en;
        io_ok   = full_on && io_en;
    end
endmodule

// File: rtl/pm_cap_ctrl.sv
module pm_cap_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CAP_DW   = 6'h10,
    parameter logic [7:0]        NEXT_PTR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_hit,
    output logic              cfg_rvalid,
    output logic [31:0]       cfg_rdata,
    input  logic              cmd_mst_en,
    input  logic              cmd_mem_en,
    input  logic              cmd_io_en,
    output logic              mst_allow,
    output logic              mem_claim_ok,
    output logic              io_claim_ok,
    output logic [1:0]        pwr_state
);
    localparam logic [31:0] ID_DWORD = {PM_CAPS_WORD, NEXT_PTR, PM_CAP_ID};

    logic       sel_id, sel_csr, rd_hit, csr_load;
    pwr_state_e state;
    logic [31:0] rd_mux;
    logic        unused_bits;

    assign unused_bits = ^{cfg_wdata[31:2], cfg_be[3:1]};

    pm_cfg_decode #(.ADDR_W(ADDR_W), .CAP_DW(CAP_DW)) u_dec (
        .rd       (cfg_rd),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .be0      (cfg_be[0]),
        .sel_id   (sel_id),
        .sel_csr  (sel_csr),
        .hit      (cfg_hit),
        .rd_hit   (rd_hit),
        .csr_load (csr_load)
    );

    pm_state_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (csr_load),
        .code  (cfg_wdata[1:0]),
        .state (state)
    );

    pm_gate u_gate (
        .state  (state),
        .mst_en (cmd_mst_en),
        .mem_en (cmd_mem_en),
        .io_en  (cmd_io_en),
        .mst_ok (mst_allow),
        .mem_ok (mem_claim_ok),
        .io_ok  (io_claim_ok)
    );

    assign pwr_state = state;

    always_comb begin
        rd_mux = '0;
        if (sel_id)       rd_mux = ID_DWORD;
        else if (sel_csr) rd_mux = {PM_DATA_BYTE, PM_BSE_BYTE, 14'd0, state};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= rd_hit;
            cfg_rdata  <= rd_hit ? rd_mux : '0;
        end
    end

    assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == CAP_DW) |=> (cfg_rvalid && cfg_rdata == ID_DWORD));

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_D0) |-> !(mst_allow || mem_claim_ok || io_claim_ok));

    assert_rvalid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd && cfg_hit));

    assert_csr_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == CAP_DW + ADDR_W'(1))
            |=> (cfg_rvalid && cfg_rdata[31:2] == 30'd0 && cfg_rdata[1:0] == pwr_state));
endmodule

// File: tb/tb_pm_cap_ctrl.sv
module tb_pm_cap_ctrl;
    localparam int unsigned ADDR_W = 6;
    localparam logic [ADDR_W-1:0] CAP = 6'h10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_rd = 0, cfg_wr = 0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic cfg_hit, cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic cmd_mst_en = 0, cmd_mem_en = 0, cmd_io_en = 0;
    logic mst_allow, mem_claim_ok, io_claim_ok;
    logic [1:0] pwr_state;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pm_cap_ctrl #(.ADDR_W(ADDR_W), .CAP_DW(CAP), .NEXT_PTR(8'h00)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string req,
                           input logic exp_hit, input logic [31:0] exp_data);
        @(negedge clk);
        cfg_rd = 1; cfg_addr = a;
        #1 chk({req, " hit"}, {31'd0, cfg_hit}, {31'd0, exp_hit});
        @(negedge clk);
        cfg_rd = 0;
        chk({req, " rvalid"}, {31'd0, cfg_rvalid}, {31'd0, exp_hit});
        if (exp_hit) chk({req, " rdata"}, cfg_rdata, exp_data);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [3:0] be,
                            input logic [1:0] code);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = {30'h3FFFFFFF, code};
        @(negedge clk);
        cfg_wr = 0; cfg_be = '0;
    endtask

    task automatic chk_gates(input string req, input logic [2:0] exp);
        chk(req, {29'd0, mst_allow, mem_claim_ok, io_claim_ok}, {29'd0, exp});
    endtask

    task automatic t_reset;
        cmd_mst_en = 1; cmd_mem_en = 1; cmd_io_en = 1;
        @(negedge clk);
        chk("R1 reset state", {30'd0, pwr_state}, 32'd0);
        chk_gates("R8 reset gates follow cmd", 3'b111);
    endtask

    task automatic t_ident;
        do_read(CAP, "R2 id dword", 1'b1, 32'h0202_0001);
        do_read(CAP + 6'd1, "R3 csr dword D0", 1'b1, 32'h0000_0000);
    endtask

    task automatic t_transitions;
        do_write(CAP + 6'd1, 4'b0001, 2'b01);
        chk("R4 load D1", {30'd0, pwr_state}, 32'd1);
        chk_gates("R7 gates off in D1", 3'b000);
        do_read(CAP + 6'd1, "R3 csr dword D1", 1'b1, 32'h0000_0001);
        do_write(CAP + 6'd1, 4'b1111, 2'b11);
        chk("R4 load D3hot", {30'd0, pwr_state}, 32'd3);
        chk_gates("R7 gates off in D3hot", 3'b000);
        do_read(CAP + 6'd1, "R3 csr dword D3hot", 1'b1, 32'h0000_0003);
        do_read(CAP, "R9 id read in D3hot", 1'b1, 32'h0202_0001);
        do_write(CAP + 6'd1, 4'b0001, 2'b00);
        chk("R4 back to D0", {30'd0, pwr_state}, 32'd0);
        chk_gates("R8 gates restored", 3'b111);
    endtask

    task automatic t_d2;
        do_write(CAP + 6'd1, 4'b0001, 2'b10);
        chk("R5 D2 ignored from D0", {30'd0, pwr_state}, 32'd0);
        do_write(CAP + 6'd1, 4'b0001, 2'b01);
        do_write(CAP + 6'd1, 4'b0001, 2'b10);
        chk("R5 D2 ignored from D1", {30'd0, pwr_state}, 32'd1);
        do_write(CAP + 6'd1, 4'b0001, 2'b00);
    endtask

    task automatic t_readonly;
        do_write(CAP + 6'd1, 4'b1110, 2'b01);
        chk("R6 be0 clear ignored", {30'd0, pwr_state}, 32'd0);
        do_write(CAP, 4'b1111, 2'b11);
        chk("R6 id dword write ignored", {30'd0, pwr_state}, 32'd0);
        do_read(CAP, "R6 id dword unchanged", 1'b1, 32'h0202_0001);
    endtask

    task automatic t_range;
        do_read(CAP + 6'd2, "R9 outside window", 1'b0, 32'd0);
        do_read(CAP - 6'd1, "R9 below window", 1'b0, 32'd0);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = CAP + 6'd1; cfg_be = 4'b0001; cfg_wdata = 32'd3;
        #1 chk("R9 write hit", {31'd0, cfg_hit}, 32'd1);
        @(negedge clk);
        cfg_wr = 0; cfg_be = '0;
        do_read(CAP + 6'd1, "R9 csr read in D3hot", 1'b1, 32'h0000_0003);
        do_write(CAP + 6'd1, 4'b0001, 2'b00);
    endtask

    task automatic t_cmd_mix;
        cmd_mst_en = 1; cmd_mem_en = 0; cmd_io_en = 1;
        #1 chk_gates("R8 mixed cmd 101", 3'b101);
        cmd_mst_en = 0; cmd_mem_en = 1; cmd_io_en = 0;
        #1 chk_gates("R8 mixed cmd 010", 3'b010);
        do_write(CAP + 6'd1, 4'b0001, 2'b11);
        cmd_mst_en = 1; cmd_mem_en = 1; cmd_io_en = 1;
        #1 chk_gates("R7 D3hot with all cmd", 3'b000);
        do_write(CAP + 6'd1, 4'b0001, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ident();
        t_transitions();
        t_d2();
        t_readonly();
        t_range();
        t_cmd_mix();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule